// File: doc/BRIEF.md
# Store-to-Load Forwarding Resolver

This block decides, for one load at a time, where the load gets its bytes. It compares the load's address range, size and age tag against every entry of a store queue. The youngest valid store that is older than the load and overlaps it decides the outcome. A store that covers every load byte forwards its data directly. A store that covers only some of the load bytes blocks the load until that store has drained. When no older store overlaps, the load reads the data cache.

Each outcome has a fixed completion latency, and a case that needs extra work pays a penalty. An accepted load starts a countdown timer. When the timer expires, the block gives a one-cycle completion pulse that carries the outcome class and the forwarded bytes. Only one load is in flight at a time. A new request that arrives while the timer runs is dropped.

Top module: `stlf_resolver`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `done` and `busy` are low.
- R2: A store entry takes part only if its valid bit is set and its age tag is strictly less than the load's age tag (unsigned compare). Invalid entries and entries with an equal or larger tag do not affect the result.
- R3: Among the participating stores whose byte range [addr, addr+size) overlaps the load's range, the one with the largest age tag decides the outcome, whatever its queue index. Sizes are coded 0,1,2,3 for 1, 2, 4 and 8 bytes.
- R4: If the deciding store covers every load byte, is naturally aligned, and neither access crosses a 64-byte line, the class is 1 and the latency is 7. The data is the store data shifted right by 8*(load address − store address), masked to the load size, with zeros above. Byte k of the store data (bits 8k+7:8k) belongs to address store address + k.
- R5: A covering store whose address is not a multiple of its size gives class 2 and latency 10 (7 plus a 3-cycle penalty), with forwarded data as in R4.
- R6: If the deciding store overlaps the load but does not cover all of its bytes, the class is 3 (blocked until the store drains) and the latency is 14. The data is zero and no bytes are merged.
- R7: If the deciding store covers the load and either access crosses a 64-byte line boundary, the class is 4 and the latency is 21, with forwarded data. This case takes precedence over R5.
- R8: With no participating overlapping store, the class is 0 (cache read), the latency is 3, and the data is zero.
- R9: A load is accepted on a rising edge where `ld_valid` is high and `busy` is low. `busy` is high after that edge. `done` is high for exactly one cycle, after the edge that comes LAT edges after acceptance, and `busy` is low in that same cycle.
- R10: `ld_valid` while `busy` is high is ignored. No extra completion occurs and the pending result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request strobe |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code (1/2/4/8 bytes) |
| ld_age | input | AGE_W | Load age tag |
| sq_valid | input | SQ_DEPTH | Store entry valid bits |
| sq_age | input | SQ_DEPTH*AGE_W | Store age tags, entry i at slice i |
| sq_addr | input | SQ_DEPTH*AW | Store byte addresses |
| sq_size | input | SQ_DEPTH*2 | Store size codes |
| sq_data | input | SQ_DEPTH*64 | Store data, byte 0 in the low bits |
| busy | output | 1 | A load is being timed |
| done | output | 1 | One-cycle completion pulse |
| done_class | output | 3 | Outcome class 0..4 |
| done_data | output | 64 | Forwarded bytes, zero for class 0 and 3 |

## Verification
Each result is due a fixed number of clock edges after the edge that accepts the load: 3 for a cache read, 7 for clean forwarding, 10 for a misaligned store, 14 for a blocked load and 21 for a line-crossing forward. When the driver issues a load, it records the edge count at which `done` must appear. The monitor samples on falling edges and compares the observed edge count, class and data against the oldest entry in its queue. Any `done` that arrives with the queue empty is reported, so a dropped request that still produces a completion shows up as an error.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

    localparam int unsigned DATA_W     = 64;
    localparam int unsigned LINE_BYTES = 64;

    typedef enum logic [2:0] {
        CLS_CACHE   = 3'd0,
        CLS_FWD     = 3'd1,
        CLS_FWD_MIS = 3'd2,
        CLS_BLOCKED = 3'd3,
        CLS_CROSS   = 3'd4
    } ld_class_e;

    typedef struct packed {
        ld_class_e          cls;
        logic [DATA_W-1:0]  data;
    } ld_result_t;

    typedef struct packed {
        logic       hit;
        logic       contained;
        logic       crossing;
        logic       misaligned;
        logic [2:0] offset;
    } cmp_flags_t;

    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/stlf_entry_cmp.sv
module stlf_entry_cmp
    import stlf_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned AGE_W = 8
) (
    input  logic             st_valid,
    input  logic [AGE_W-1:0] st_age,
    input  logic [AW-1:0]    st_addr,
    input  logic [1:0]       st_size,
    input  logic [AW-1:0]    ld_addr,
    input  logic [1:0]       ld_size,
    input  logic [AGE_W-1:0] ld_age,
    output cmp_flags_t       flags
);

    logic [3:0]  st_bytes, ld_bytes;
    logic [AW:0] st_lo, st_hi, ld_lo, ld_hi;
    logic [6:0]  st_line_end, ld_line_end;
    logic        older, overlap;
    logic [2:0]  align_mask;

    always_comb begin
        st_bytes    = size_bytes(st_size);
        ld_bytes    = size_bytes(ld_size);
        st_lo       = {1'b0, st_addr};
        ld_lo       = {1'b0, ld_addr};
        st_hi       = st_lo + {{(AW-3){1'b0}}, st_bytes};
        ld_hi       = ld_lo + {{(AW-3){1'b0}}, ld_bytes};
        st_line_end = {1'b0, st_addr[5:0]} + {3'b000, st_bytes};
        ld_line_end = {1'b0, ld_addr[5:0]} + {3'b000, ld_bytes};
        older       = st_valid && (st_age < ld_age);
        overlap     = (ld_lo < st_hi) && (st_lo < ld_hi);
        align_mask  = st_bytes[2:0] - 3'd1;

        flags.hit        = older && overlap;
        flags.contained  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        flags.crossing   = (st_line_end > 7'(LINE_BYTES)) || (ld_line_end > 7'(LINE_BYTES));
        flags.misaligned = (st_addr[2:0] & align_mask) != 3'd0;
        flags.offset     = ld_addr[2:0] - st_addr[2:0];
    end

endmodule

// File: rtl/stlf_pick.sv
module stlf_pick #(
    parameter int unsigned N     = 64,
    parameter int unsigned AGE_W = 8,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       hit,
    input  logic [N*AGE_W-1:0] ages,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    logic [AGE_W-1:0] best_age;

    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best_age = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (hit[i] && (!any || ages[i*AGE_W +: AGE_W] > best_age)) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                best_age = ages[i*AGE_W +: AGE_W];
            end
        end
    end

    AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (rst)
        any |-> hit[idx]);  // R3

    AST_PICK_FOUND: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> any);  // R3

endmodule

// File: rtl/stlf_timer.sv
module stlf_timer
    import stlf_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] lat,
    input  ld_result_t       res_in,
    output logic             busy,
    output logic             done,
    output ld_result_t       res_out
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            res_out <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                cnt     <= lat;
                busy    <= 1'b1;
                res_out <= res_in;
            end else if (busy) begin
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));  // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R9

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);  // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(res_out));  // R10

endmodule

// File: rtl/stlf_resolver.sv
module stlf_resolver
    import stlf_pkg::*;
#(
    parameter int unsigned SQ_DEPTH    = 64,
    parameter int unsigned AW          = 16,
    parameter int unsigned AGE_W       = 8,
    parameter int unsigned LAT_HIT     = 3,
    parameter int unsigned LAT_FWD     = 7,
    parameter int unsigned LAT_MIS_ADD = 3,
    parameter int unsigned LAT_BLOCK   = 14,
    parameter int unsigned LAT_CROSS   = 21
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_valid,
    input  logic [AW-1:0]             ld_addr,
    input  logic [1:0]                ld_size,
    input  logic [AGE_W-1:0]          ld_age,
    input  logic [SQ_DEPTH-1:0]       sq_valid,
    input  logic [SQ_DEPTH*AGE_W-1:0] sq_age,
    input  logic [SQ_DEPTH*AW-1:0]    sq_addr,
    input  logic [SQ_DEPTH*2-1:0]     sq_size,
    input  logic [SQ_DEPTH*64-1:0]    sq_data,
    output logic                      busy,
    output logic                      done,
    output logic [2:0]                done_class,
    output logic [63:0]               done_data
);

    localparam int unsigned IDX_W   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1;
    localparam int unsigned LAT_SUM = LAT_HIT + LAT_FWD + LAT_MIS_ADD + LAT_BLOCK + LAT_CROSS;
    localparam int unsigned CNT_W   = $clog2(LAT_SUM + 1);

    cmp_flags_t          flags [SQ_DEPTH];
    logic [SQ_DEPTH-1:0] hit_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    win_idx;
    cmp_flags_t          win;
    logic [DATA_W-1:0]   win_data;
    logic [DATA_W-1:0]   fwd_data;
    ld_result_t          res_now, res_q;
    logic [CNT_W-1:0]    lat_now;

    for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_entry
        stlf_entry_cmp #(.AW(AW), .AGE_W(AGE_W)) i_cmp (
            .st_valid (sq_valid[g]),
            .st_age   (sq_age[g*AGE_W +: AGE_W]),
            .st_addr  (sq_addr[g*AW +: AW]),
            .st_size  (sq_size[g*2 +: 2]),
            .ld_addr  (ld_addr),
            .ld_size  (ld_size),
            .ld_age   (ld_age),
            .flags    (flags[g])
        );
        assign hit_vec[g] = flags[g].hit;
    end

    stlf_pick #(.N(SQ_DEPTH), .AGE_W(AGE_W)) i_pick (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit_vec),
        .ages (sq_age),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_comb begin
        win      = flags[win_idx];
        win_data = sq_data[win_idx*64 +: 64];
        fwd_data = (win_data >> {win.offset, 3'b000}) & byte_mask(ld_size);

        res_now.data = '0;
        if (!any_hit) begin
            res_now.cls = CLS_CACHE;
            lat_now     = CNT_W'(LAT_HIT);
        end else if (!win.contained) begin
            res_now.cls = CLS_BLOCKED;
            lat_now     = CNT_W'(LAT_BLOCK);
        end else if (win.crossing) begin
            res_now.cls  = CLS_CROSS;
            res_now.data = fwd_data;
            lat_now      = CNT_W'(LAT_CROSS);
        end else if (win.misaligned) begin
            res_now.cls  = CLS_FWD_MIS;
            res_now.data = fwd_data;
            lat_now      = CNT_W'(LAT_FWD + LAT_MIS_ADD);
        end else begin
            res_now.cls  = CLS_FWD;
            res_now.data = fwd_data;
            lat_now      = CNT_W'(LAT_FWD);
        end
    end

    stlf_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (ld_valid),
        .lat     (lat_now),
        .res_in  (res_now),
        .busy    (busy),
        .done    (done),
        .res_out (res_q)
    );

    assign done_class = res_q.cls;
    assign done_data  = res_q.data;

    AST_BLOCKED_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (done && done_class == CLS_BLOCKED) |-> (done_data == '0));  // R6

    AST_CACHE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (done && done_class == CLS_CACHE) |-> (done_data == '0));  // R8

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_class <= 3'd4));  // R3

endmodule

// File: tb/test_stlf_resolver.sv
module test_stlf_resolver;

    localparam int N  = 64;
    localparam int AW = 16;
    localparam int AG = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld_valid = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [1:0]      ld_size = '0;
    logic [AG-1:0]   ld_age = '0;
    logic [N-1:0]    sq_valid = '0;
    logic [N*AG-1:0] sq_age = '0;
    logic [N*AW-1:0] sq_addr = '0;
    logic [N*2-1:0]  sq_size = '0;
    logic [N*64-1:0] sq_data = '0;
    logic            busy, done;
    logic [2:0]      done_class;
    logic [63:0]     done_data;

    stlf_resolver i_stlf_resolver (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_size(ld_size), .ld_age(ld_age), .sq_valid(sq_valid),
        .sq_age(sq_age), .sq_addr(sq_addr), .sq_size(sq_size),
        .sq_data(sq_data), .busy(busy), .done(done),
        .done_class(done_class), .done_data(done_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          cls;
        logic [63:0] data;
        int          due;
        string       rq;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    localparam logic [63:0] D1 = 64'h8877_6655_4433_2211;
    localparam logic [63:0] D2 = 64'h0123_4567_89AB_CDEF;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each completion with the oldest expectation
    always @(negedge clk) begin
        if (!rst && done) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected done at cycle %0d (class %0d data %h), expected none",
                         cyc, done_class, done_data);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (int'(done_class) != e.cls || done_data != e.data || cyc != e.due) begin
                    errors++;
                    $display("FAIL %s: class %0d data %h cycle %0d, expected class %0d data %h cycle %0d",
                             e.rq, done_class, done_data, cyc, e.cls, e.data, e.due);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    task automatic clear_sq();
        sq_valid = '0;
    endtask

    task automatic put(input int idx, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [AG-1:0] age, input logic [63:0] d);
        sq_valid[idx]          = 1'b1;
        sq_addr[idx*AW +: AW]  = a;
        sq_size[idx*2 +: 2]    = sz;
        sq_age[idx*AG +: AG]   = age;
        sq_data[idx*64 +: 64]  = d;
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [1:0] sz, input logic [AG-1:0] age,
                         input int cls, input logic [63:0] d, input int lat, input string rq);
        exp_t e;
        @(negedge clk);
        ld_addr  = a;
        ld_size  = sz;
        ld_age   = age;
        ld_valid = 1'b1;
        e.cls = cls; e.data = d; e.due = cyc + 1 + lat; e.rq = rq;
        expq.push_back(e);
        @(negedge clk);
        ld_valid = 1'b0;
        checks++;
        if (busy !== 1'b1) begin
            errors++;
            $display("FAIL R9: busy %b after accept, expected 1", busy);
        end
        repeat (lat + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: done %b busy %b in reset, expected 0 0", done, busy);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: done %b busy %b after reset, expected 0 0", done, busy);
        end

        // R8: empty queue reads cache
        clear_sq();
        issue(16'h0100, 2'd3, 8'd50, 0, 64'h0, 3, "R8");

        // R4: contained aligned forward, offset 2
        put(10, 16'h0100, 2'd3, 8'd5, D1);
        issue(16'h0102, 2'd1, 8'd9, 1, 64'h4433, 7, "R4");

        // R4: full 8-byte forward from far entry 63
        clear_sq();
        put(63, 16'h0180, 2'd3, 8'd2, D2);
        issue(16'h0180, 2'd3, 8'd9, 1, D2, 7, "R4");

        // R5: misaligned 4-byte store at 0x103
        clear_sq();
        put(4, 16'h0103, 2'd2, 8'd5, D1);
        issue(16'h0104, 2'd0, 8'd9, 2, 64'h22, 10, "R5");

        // R6: partial overlap blocks
        clear_sq();
        put(7, 16'h0200, 2'd2, 8'd5, D1);
        issue(16'h0202, 2'd2, 8'd9, 3, 64'h0, 14, "R6");

        // R7: store crosses line 0x140, also misaligned; crossing wins
        clear_sq();
        put(3, 16'h013E, 2'd2, 8'd5, D1);
        issue(16'h013F, 2'd0, 8'd9, 4, 64'h22, 21, "R7");

        // R8: adjacent store, no overlap
        clear_sq();
        put(0, 16'h0300, 2'd2, 8'd5, D1);
        issue(16'h0304, 2'd2, 8'd9, 0, 64'h0, 3, "R8");

        // R2: equal and younger ages are ignored
        clear_sq();
        put(0, 16'h0200, 2'd3, 8'd20, D1);
        put(1, 16'h0200, 2'd3, 8'd10, D2);
        issue(16'h0200, 2'd1, 8'd10, 0, 64'h0, 3, "R2");

        // R2: invalid entry ignored
        clear_sq();
        sq_addr[5*AW +: AW] = 16'h0200;
        sq_size[5*2 +: 2]   = 2'd3;
        sq_age[5*AG +: AG]  = 8'd1;
        issue(16'h0200, 2'd0, 8'd10, 0, 64'h0, 3, "R2");

        // R3: youngest older store wins regardless of index
        clear_sq();
        put(0, 16'h0200, 2'd3, 8'd7, D2);
        put(5, 16'h0200, 2'd3, 8'd3, D1);
        issue(16'h0200, 2'd1, 8'd9, 1, 64'hCDEF, 7, "R3");

        // R3: younger partial store overrides older covering store
        clear_sq();
        put(1, 16'h0280, 2'd3, 8'd4, D1);
        put(2, 16'h0284, 2'd2, 8'd6, D2);
        issue(16'h0283, 2'd1, 8'd8, 3, 64'h0, 14, "R3");

        // R3: same setup, load older than the partial store -> covering store forwards
        issue(16'h0283, 2'd1, 8'd5, 1, 64'h5544, 7, "R3");

        // R10: request during busy is dropped
        clear_sq();
        put(2, 16'h0400, 2'd2, 8'd5, D1);
        @(negedge clk);
        ld_addr = 16'h0500; ld_size = 2'd0; ld_age = 8'd9; ld_valid = 1'b1;
        begin
            exp_t e;
            e.cls = 0; e.data = 64'h0; e.due = cyc + 1 + 3; e.rq = "R10";
            expq.push_back(e);
        end
        @(negedge clk);
        ld_addr = 16'h0402; ld_size = 2'd2;   // would be blocked if taken
        @(negedge clk);
        ld_valid = 1'b0;
        repeat (30) @(negedge clk);

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d completions missing, expected 0", expq.size());
        end
        finish_run();
    end

endmodule